// File: doc/BRIEF.md
# Four-Activate Window Limiter

This block watches the activate commands that a DRAM command scheduler issues and tells it, for every rank, whether one more activate may go out without putting five activates inside one sliding window. The window length is given in memory-bus cycles on an input and may be anywhere from 1 to 62 cycles. Refresh commands occupy a window slot just as activates do, so the scheduler raises the same strobe for both.

Each rank keeps a shift register as long as the longest window. A recorded command places a one at the position that is the window length minus one. That one walks toward bit 0 by one place per cycle. Alongside it, a small counter holds the number of ones in that register. The per-rank permit is taken from the registered counter, so a command issued in a cycle cannot see its own effect until the following cycle. Choosing which command to issue, and every other DRAM timing rule, belongs to the scheduler.

Top module: `faw_limiter`

## Requirements
- R1: While reset is high and in the first cycle after it, every bit of `act_ok` is 1 and no earlier command is remembered.
- R2: An activate or refresh is recorded on the rising edge where `act_valid` is 1, for the rank on `act_rank`. A rank's `act_ok` bit is 1 while fewer than 4 recorded commands are live, and goes to 0 right after the edge that records the fourth live one.
- R3: With an effective window length of L, a command recorded at edge k counts as live after edges k through k+L-1. It stops counting at edge k+L.
- R4: Each bit of `act_ok` (bit r for rank r) depends only on the commands recorded for rank r. Commands to other ranks have no effect on it.
- R5: When a rank's oldest live command expires on the same edge that records a new command for that rank, the live count stays the same. A rank that was at 4 stays blocked.
- R6: `win_len` sets L. A value of 0 acts as L=1, and values above 62 act as L=62.
- R7: A command is recorded even when its rank is blocked. The rank then stays blocked until its live count drops below 4 again.
- R8: A strobe whose `act_rank` is not below the number of ranks (6 by default, so 6 and 7) records nothing. No bit of `act_ok` changes because of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-bus clock |
| rst | input | 1 | Synchronous reset, active high |
| act_valid | input | 1 | An activate or refresh is issued this cycle |
| act_rank | input | 3 | Rank index of the issued command |
| win_len | input | 6 | Window length in bus cycles (clamped to 1..62) |
| act_ok | output | 6 | Bit r is 1 when rank r may take another activate |

## Verification
The interesting coincidence is one rank's oldest entry leaving the window on the same edge that a new command for that rank arrives. Here the counter has to take a decrement and an increment together. The bench sets this up by issuing four commands back to back and then a fifth exactly L edges after the first. It expects `act_ok` for that rank to stay 0. A reference model built on timestamps gives the expected vector after every edge, and the scoreboard compares it with the design's output. Bursts of five commands, clamped window lengths, and strobes with out-of-range rank indices are judged against the same model.

// File: rtl/fawl_pkg.sv
package fawl_pkg;

    localparam int ACT_LIMIT_DEF = 4;
    localparam int WIN_MAX_DEF   = 62;
    localparam int RANKS_DEF     = 6;

    function automatic int bits_for(input int max_value);
        return (max_value < 2) ? 1 : $clog2(max_value + 1);
    endfunction

    function automatic int index_bits(input int count);
        return (count < 2) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/fawl_len_clamp.sv
module fawl_len_clamp #(
    parameter int WIN_MAX = fawl_pkg::WIN_MAX_DEF,
    parameter int LEN_W   = fawl_pkg::bits_for(WIN_MAX)
) (
    input  logic [LEN_W-1:0] len_raw,
    output logic [LEN_W-1:0] len_eff
);
    localparam logic [LEN_W-1:0] LEN_TOP = LEN_W'(WIN_MAX);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    always_comb begin
        if (len_raw == '0) begin
            len_eff = LEN_ONE;
        end else if (len_raw > LEN_TOP) begin
            len_eff = LEN_TOP;
        end else begin
            len_eff = len_raw;
        end
    end
endmodule

// File: rtl/fawl_act_decode.sv
module fawl_act_decode #(
    parameter int NUM_RANKS = fawl_pkg::RANKS_DEF,
    parameter int RANK_W    = fawl_pkg::index_bits(NUM_RANKS)
) (
    input  logic                 act_valid,
    input  logic [RANK_W-1:0]    act_rank,
    output logic [NUM_RANKS-1:0] mark
);
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_sel
        assign mark[r] = act_valid && (act_rank == RANK_W'(r));
    end
endmodule

// File: rtl/fawl_rank_tracker.sv
module fawl_rank_tracker #(
    parameter int WIN_MAX   = fawl_pkg::WIN_MAX_DEF,
    parameter int ACT_LIMIT = fawl_pkg::ACT_LIMIT_DEF,
    parameter int LEN_W     = fawl_pkg::bits_for(WIN_MAX),
    parameter int CNT_W     = fawl_pkg::bits_for(WIN_MAX)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mark,
    input  logic [LEN_W-1:0]   len_eff,
    output logic [WIN_MAX-1:0] bits_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               act_ok
);
    localparam logic [WIN_MAX-1:0] ONE_HOT0 = WIN_MAX'(1);
    localparam logic [CNT_W-1:0]   LIMIT_C  = CNT_W'(ACT_LIMIT);

    logic [WIN_MAX-1:0] shifted;
    logic [WIN_MAX-1:0] entry_bit;
    logic [WIN_MAX-1:0] bits_d;
    logic [CNT_W-1:0]   cnt_aged;
    logic [CNT_W-1:0]   cnt_d;
    logic               slot_taken;

    always_comb begin
        // Age first, then place the new entry on the aged pattern.
        shifted    = bits_q >> 1;
        cnt_aged   = cnt_q - CNT_W'(bits_q[0]);
        entry_bit  = ONE_HOT0 << (len_eff - LEN_W'(1));
        slot_taken = |(shifted & entry_bit);
        bits_d     = shifted;
        cnt_d      = cnt_aged;
        if (mark) begin
            bits_d = shifted | entry_bit;
            if (!slot_taken) begin
                cnt_d = cnt_aged + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else begin
            bits_q <= bits_d;
            cnt_q  <= cnt_d;
        end
    end

    assign act_ok = (cnt_q < LIMIT_C);
endmodule

// File: rtl/faw_limiter.sv
module faw_limiter #(
    parameter int NUM_RANKS = fawl_pkg::RANKS_DEF,
    parameter int WIN_MAX   = fawl_pkg::WIN_MAX_DEF,
    parameter int ACT_LIMIT = fawl_pkg::ACT_LIMIT_DEF,
    parameter int RANK_W    = fawl_pkg::index_bits(NUM_RANKS),
    parameter int LEN_W     = fawl_pkg::bits_for(WIN_MAX)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 act_valid,
    input  logic [RANK_W-1:0]    act_rank,
    input  logic [LEN_W-1:0]     win_len,
    output logic [NUM_RANKS-1:0] act_ok
);
    localparam int CNT_W = fawl_pkg::bits_for(WIN_MAX);

    logic [LEN_W-1:0]                    len_eff;
    logic [NUM_RANKS-1:0]                rank_mark;
    logic [NUM_RANKS-1:0][WIN_MAX-1:0]   rank_bits;
    logic [NUM_RANKS-1:0][CNT_W-1:0]     rank_cnt;

    fawl_len_clamp #(.WIN_MAX(WIN_MAX), .LEN_W(LEN_W)) u_clamp (
        .len_raw (win_len),
        .len_eff (len_eff)
    );

    fawl_act_decode #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_decode (
        .act_valid (act_valid),
        .act_rank  (act_rank),
        .mark      (rank_mark)
    );

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        fawl_rank_tracker #(
            .WIN_MAX   (WIN_MAX),
            .ACT_LIMIT (ACT_LIMIT),
            .LEN_W     (LEN_W),
            .CNT_W     (CNT_W)
        ) u_track (
            .clk     (clk),
            .rst     (rst),
            .mark    (rank_mark[r]),
            .len_eff (len_eff),
            .bits_q  (rank_bits[r]),
            .cnt_q   (rank_cnt[r]),
            .act_ok  (act_ok[r])
        );
    end
endmodule

// File: rtl/fawl_checker.sv
module fawl_checker #(
    parameter int NUM_RANKS = 6,
    parameter int WIN_MAX   = 62,
    parameter int RANK_W    = 3,
    parameter int CNT_W     = 6
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               act_valid,
    input logic [RANK_W-1:0]                  act_rank,
    input logic [NUM_RANKS-1:0]               act_ok,
    input logic [NUM_RANKS-1:0][WIN_MAX-1:0]  rank_bits,
    input logic [NUM_RANKS-1:0][CNT_W-1:0]    rank_cnt
);
    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    AST_OPEN_AFTER_RESET: assert property (@(posedge clk)
        (rst_d && !rst) |-> (&act_ok)); // R1

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
        AST_COUNT_TRACKS_BITS: assert property (@(posedge clk) disable iff (rst)
            rank_cnt[r] == CNT_W'($countones(rank_bits[r]))); // R3

        AST_BLOCK_NEEDS_MARK: assert property (@(posedge clk) disable iff (rst)
            $fell(act_ok[r]) |-> $past(act_valid && (act_rank == RANK_W'(r)))); // R2

        AST_RELEASE_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
            $rose(act_ok[r]) |-> $past(rank_bits[r][0])); // R3

        AST_NO_GROWTH_UNMARKED: assert property (@(posedge clk) disable iff (rst)
            !(act_valid && (act_rank == RANK_W'(r))) |=> (rank_cnt[r] <= $past(rank_cnt[r]))); // R4
    end
endmodule

bind faw_limiter fawl_checker #(
    .NUM_RANKS (NUM_RANKS),
    .WIN_MAX   (WIN_MAX),
    .RANK_W    (RANK_W),
    .CNT_W     (CNT_W)
) u_fawl_checker (
    .clk       (clk),
    .rst       (rst),
    .act_valid (act_valid),
    .act_rank  (act_rank),
    .act_ok    (act_ok),
    .rank_bits (rank_bits),
    .rank_cnt  (rank_cnt)
);

// File: tb/faw_limiter_bench.sv
`timescale 1ns/1ps
module faw_limiter_bench;
    localparam int NR   = 6;
    localparam int RW   = 3;
    localparam int LW   = 6;
    localparam int LIM  = 4;
    localparam int WMAX = 62;

    typedef struct {
        logic [NR-1:0] exp;
        string         tag;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          act_valid = 1'b0;
    logic [RW-1:0] act_rank = '0;
    logic [LW-1:0] win_len = 6'd8;
    logic [NR-1:0] act_ok;

    int compared   = 0;
    int mismatched = 0;
    int edge_n     = 0;
    bit done       = 0;
    sb_item_t sbq[$];
    int stamps[NR][$];

    always #2 clk = ~clk;

    faw_limiter u_faw_limiter (
        .clk       (clk),
        .rst       (rst),
        .act_valid (act_valid),
        .act_rank  (act_rank),
        .win_len   (win_len),
        .act_ok    (act_ok)
    );

    function automatic int eff_len(input int raw);
        if (raw == 0) return 1;
        if (raw > WMAX) return WMAX;
        return raw;
    endfunction

    function automatic logic [NR-1:0] model_vec(input int e, input int len);
        logic [NR-1:0] v;
        for (int r = 0; r < NR; r++) begin
            int live = 0;
            foreach (stamps[r][i]) begin
                if (stamps[r][i] > e - len && stamps[r][i] <= e) live++;
            end
            v[r] = (live < LIM);
        end
        return v;
    endfunction

    task automatic step(input bit v, input int rk, input string tag);
        sb_item_t it;
        @(negedge clk);
        act_valid = v;
        act_rank  = RW'(rk);
        @(posedge clk);
        #1;
        edge_n++;
        if (v && rk < NR) stamps[rk].push_back(edge_n);
        it.exp = model_vec(edge_n, eff_len(int'(win_len)));
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, tag);
    endtask

    task automatic do_reset(input int len);
        @(negedge clk);
        rst = 1'b1;
        act_valid = 1'b0;
        win_len = LW'(len);
        repeat (3) @(posedge clk);
        #1;
        if (act_ok !== {NR{1'b1}}) begin
            mismatched++;
            $display("FAIL R1 in reset: act_ok=%b expected=%b", act_ok, {NR{1'b1}});
        end
        compared++;
        @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < NR; r++) stamps[r].delete();
        step(1'b0, 0, "R1");
    endtask

    // Monitor: compare one queued expectation per cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                compared++;
                if (act_ok !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: act_ok=%b expected=%b", it.tag, act_ok, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R2, R3, R4: four back to back on rank 2, rank 5 runs alongside
        do_reset(8);
        for (int i = 0; i < 4; i++) step(1'b1, 2, "R2");
        step(1'b1, 5, "R4");
        step(1'b1, 5, "R4");
        idle(10, "R3");
        for (int i = 0; i < 3; i++) step(1'b1, 4, "R2");
        idle(3, "R2");

        // R5: expiry and new mark on the same edge
        do_reset(8);
        for (int i = 0; i < 4; i++) step(1'b1, 1, "R5");
        idle(4, "R5");
        step(1'b1, 1, "R5");
        idle(10, "R5");

        // R7: fifth command while blocked
        do_reset(8);
        for (int i = 0; i < 5; i++) step(1'b1, 0, "R7");
        idle(12, "R7");

        // R6: zero length acts as one
        do_reset(0);
        for (int i = 0; i < 8; i++) step(1'b1, 3, "R6");
        idle(2, "R6");

        // R6: oversize length acts as 62
        do_reset(63);
        for (int i = 0; i < 4; i++) step(1'b1, 3, "R6");
        idle(64, "R6");

        // R8: out-of-range rank strobes record nothing
        do_reset(8);
        for (int i = 0; i < 3; i++) step(1'b1, 0, "R8");
        for (int i = 0; i < 4; i++) step(1'b1, 6 + (i % 2), "R8");
        idle(10, "R8");

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule